// File: doc/BRIEF.md
# Two-Level Branch Target Tree Cache

This block sits in the fetch stage of a wide-issue front end. Each cycle it takes one fetch address and returns the start addresses of the next two basic blocks, so that one lookup is enough to fetch several non-contiguous blocks at once. Each entry is tagged and holds a small tree of targets. The tree has a taken and a not-taken successor for the first branch. For each of those two paths it also holds the taken and not-taken successor of the branch that follows, and a valid bit and a type field for that branch.

Two direction predictions come from an external predictor together with the lookup. They walk the tree: the first prediction picks the block-2 address, and both predictions together pick the block-3 address. When the lookup misses, both outputs are invalid and the fetch unit falls back to sequential fetch. A write port, fed by branch resolution, loads one whole entry per cycle. The storage is direct-mapped with a registered read, so results appear one cycle after the lookup.

Top module: `brtc_top`

## Requirements
- R1: After reset every entry is empty, so any lookup made before the first fill reports both valid flags low.
- R2: Results for a lookup presented at clock edge k appear after edge k and hold until edge k+1. In a cycle that follows an edge without a lookup request, `b2_valid` and `b3_valid` are low.
- R3: With ENTRIES=32 the entry index is address bits [6:2] and the tag is bits [31:7]. A lookup hits only when the indexed entry is valid and its tag equals the lookup tag. On a miss, both valid flags are low and all address and type outputs are zero.
- R4: On a hit `b2_valid` is high. `lk_pred[0]` is the primary prediction (1 = taken): 1 selects the stored taken address and 0 selects the not-taken address as `b2_addr`.
- R5: The block-3 address is chosen by {lk_pred[0], lk_pred[1]}: 11 gives taken-taken, 10 gives taken-not, 01 gives not-taken-taken, 00 gives not-not.
- R6: `b3_valid` is high only on a hit whose secondary branch on the predicted primary path is valid. That is the taken-path valid bit when lk_pred[0]=1 and the not-taken-path valid bit otherwise. When `b3_valid` is low, `b3_addr` and `b3_type` are zero.
- R7: On a hit `b2_type` carries the stored primary type. When `b3_valid` is high, `b3_type` carries the stored secondary type of the predicted primary path.
- R8: A write loads the whole entry at the index of `wr_addr`, replacing its tag and all fields. A lookup at the next edge or later sees the new content, and an address that aliased to the old tag now misses.
- R9: A lookup and a write to the same index at the same edge return the entry content from before that write.
- R10: A write with `wr_valid` low empties the entry, so later lookups at that address miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_addr | input | 32 | Fetch address to look up |
| lk_pred | input | 2 | [0] primary prediction, [1] secondary prediction, 1 = taken |
| wr_en | input | 1 | Write one whole entry |
| wr_addr | input | 32 | Fetch address that owns the entry |
| wr_valid | input | 1 | Primary branch valid (0 empties the entry) |
| wr_type | input | 2 | Primary branch type |
| wr_taddr | input | 32 | Primary taken target |
| wr_naddr | input | 32 | Primary fall-through address |
| wr_st_valid | input | 1 | Secondary branch valid on the taken path |
| wr_st_type | input | 2 | Secondary branch type on the taken path |
| wr_sn_valid | input | 1 | Secondary branch valid on the not-taken path |
| wr_sn_type | input | 2 | Secondary branch type on the not-taken path |
| wr_tt | input | 32 | Taken-taken address |
| wr_tn | input | 32 | Taken-not address |
| wr_nt | input | 32 | Not-taken-taken address |
| wr_nn | input | 32 | Not-not address |
| b2_valid | output | 1 | Block-2 address valid (hit) |
| b2_addr | output | 32 | Start address of block 2 |
| b2_type | output | 2 | Primary branch type |
| b3_valid | output | 1 | Block-3 address valid |
| b3_addr | output | 32 | Start address of block 3 |
| b3_type | output | 2 | Secondary branch type on the chosen path |

## Verification
A corrupted valid bit or tag shows in the very next cycle after a lookup. It appears as a false miss with both flags low, or as a false hit that carries another branch's targets. A fault in the tree walk does not flip any flag. It appears only as a wrong `b2_addr` or `b3_addr` for particular prediction pairs, so every pair is applied against entries whose secondary valid bits differ. A broken write path appears at the first lookup after the fill. A broken read-before-write ordering appears only when a write and a lookup hit the same index in one cycle.

// File: rtl/brtc_pkg.sv
package brtc_pkg;
  localparam int AW = 32;
  localparam int TW = 2;

  typedef struct packed {
    logic [AW-1:0] t_addr;
    logic [AW-1:0] n_addr;
    logic [AW-1:0] tt_addr;
    logic [AW-1:0] tn_addr;
    logic [AW-1:0] nt_addr;
    logic [AW-1:0] nn_addr;
    logic [TW-1:0] p_type;
    logic [TW-1:0] st_type;
    logic [TW-1:0] sn_type;
    logic          st_valid;
    logic          sn_valid;
  } tree_t;

  // first level of the walk: primary prediction picks block 2
  function automatic logic [AW-1:0] walk_l1(tree_t t, logic p0);
    return p0 ? t.t_addr : t.n_addr;
  endfunction

  // second level: both predictions pick block 3
  function automatic logic [AW-1:0] walk_l2(tree_t t, logic p0, logic p1);
    logic [AW-1:0] r;
    case ({p0, p1})
      2'b11:   r = t.tt_addr;
      2'b10:   r = t.tn_addr;
      2'b01:   r = t.nt_addr;
      default: r = t.nn_addr;
    endcase
    return r;
  endfunction

  function automatic logic sec_ok(tree_t t, logic p0);
    return p0 ? t.st_valid : t.sn_valid;
  endfunction

  function automatic logic [TW-1:0] sec_type(tree_t t, logic p0);
    return p0 ? t.st_type : t.sn_type;
  endfunction
endpackage

// File: rtl/brtc_store.sv
module brtc_store
  import brtc_pkg::*;
#(
  parameter int ENTRIES = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_valid,
  input  tree_t         wr_tree,
  output logic          rd_done,
  output logic          rd_hit,
  output tree_t         rd_tree
);
  localparam int IW  = $clog2(ENTRIES);
  localparam int TGW = AW - IW - 2;

  logic [TGW-1:0]     tag_mem  [ENTRIES];
  tree_t              tree_mem [ENTRIES];
  logic [ENTRIES-1:0] vld;
  logic [ENTRIES-1:0] wr_sel;

  wire [IW-1:0]  wr_idx = wr_addr[IW+1:2];
  wire [IW-1:0]  rd_idx = rd_addr[IW+1:2];
  wire [TGW-1:0] wr_tag = wr_addr[AW-1:IW+2];
  wire [TGW-1:0] rd_tag = rd_addr[AW-1:IW+2];

  // one-hot write decode, one bit per entry
  for (genvar g = 0; g < ENTRIES; g++) begin : g_wsel
    assign wr_sel[g] = wr_en && (wr_idx == IW'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else        vld <= (vld & ~wr_sel) | (wr_sel & {ENTRIES{wr_valid}});
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      tree_mem[wr_idx] <= wr_tree;
    end
  end

  // registered read: old contents are captured when a write hits the same edge
  logic [TGW-1:0] q_tag, q_etag;
  logic           q_evld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_done <= 1'b0;
      q_evld  <= 1'b0;
    end else begin
      rd_done <= rd_en;
      if (rd_en) q_evld <= vld[rd_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      q_tag   <= rd_tag;
      q_etag  <= tag_mem[rd_idx];
      rd_tree <= tree_mem[rd_idx];
    end
  end

  wire tag_eq = (q_etag == q_tag);
  assign rd_hit = rd_done && q_evld && tag_eq;
endmodule

// File: rtl/brtc_select.sv
module brtc_select
  import brtc_pkg::*;
(
  input  logic          hit,
  input  tree_t         tree,
  input  logic [1:0]    pred,
  output logic          b2_valid,
  output logic [AW-1:0] b2_addr,
  output logic [TW-1:0] b2_type,
  output logic          b3_valid,
  output logic [AW-1:0] b3_addr,
  output logic [TW-1:0] b3_type
);
  wire path_ok = sec_ok(tree, pred[0]);

  always_comb begin
    b2_valid = hit;
    b2_addr  = hit ? walk_l1(tree, pred[0]) : '0;
    b2_type  = hit ? tree.p_type : '0;
    b3_valid = hit && path_ok;
    b3_addr  = b3_valid ? walk_l2(tree, pred[0], pred[1]) : '0;
    b3_type  = b3_valid ? sec_type(tree, pred[0]) : '0;
  end
endmodule

// File: rtl/brtc_top.sv
module brtc_top
  import brtc_pkg::*;
#(
  parameter int ENTRIES = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lk_valid,
  input  logic [31:0]   lk_addr,
  input  logic [1:0]    lk_pred,
  input  logic          wr_en,
  input  logic [31:0]   wr_addr,
  input  logic          wr_valid,
  input  logic [1:0]    wr_type,
  input  logic [31:0]   wr_taddr,
  input  logic [31:0]   wr_naddr,
  input  logic          wr_st_valid,
  input  logic [1:0]    wr_st_type,
  input  logic          wr_sn_valid,
  input  logic [1:0]    wr_sn_type,
  input  logic [31:0]   wr_tt,
  input  logic [31:0]   wr_tn,
  input  logic [31:0]   wr_nt,
  input  logic [31:0]   wr_nn,
  output logic          b2_valid,
  output logic [31:0]   b2_addr,
  output logic [1:0]    b2_type,
  output logic          b3_valid,
  output logic [31:0]   b3_addr,
  output logic [1:0]    b3_type
);
  tree_t      fill_tree;
  tree_t      read_tree;
  logic       lookup_done;
  logic       lookup_hit;
  logic [1:0] pred_q;

  always_comb begin
    fill_tree.t_addr   = wr_taddr;
    fill_tree.n_addr   = wr_naddr;
    fill_tree.tt_addr  = wr_tt;
    fill_tree.tn_addr  = wr_tn;
    fill_tree.nt_addr  = wr_nt;
    fill_tree.nn_addr  = wr_nn;
    fill_tree.p_type   = wr_type;
    fill_tree.st_type  = wr_st_type;
    fill_tree.sn_type  = wr_sn_type;
    fill_tree.st_valid = wr_st_valid;
    fill_tree.sn_valid = wr_sn_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pred_q <= '0;
    else if (lk_valid) pred_q <= lk_pred;
  end

  brtc_store #(.ENTRIES(ENTRIES)) i_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (lk_valid),
    .rd_addr  (lk_addr),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_valid (wr_valid),
    .wr_tree  (fill_tree),
    .rd_done  (lookup_done),
    .rd_hit   (lookup_hit),
    .rd_tree  (read_tree)
  );

  brtc_select i_select (
    .hit      (lookup_hit),
    .tree     (read_tree),
    .pred     (pred_q),
    .b2_valid (b2_valid),
    .b2_addr  (b2_addr),
    .b2_type  (b2_type),
    .b3_valid (b3_valid),
    .b3_addr  (b3_addr),
    .b3_type  (b3_type)
  );
endmodule

// File: rtl/brtc_chk.sv
module brtc_chk #(
  parameter int ENTRIES = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic        lk_valid,
  input logic [31:0] lk_addr,
  input logic        wr_en,
  input logic [31:0] wr_addr,
  input logic        wr_valid,
  input logic        hit,
  input logic        b2_valid,
  input logic        b3_valid
);
  localparam int IW = $clog2(ENTRIES);
  wire [IW-1:0] lk_idx = lk_addr[IW+1:2];
  wire [IW-1:0] wr_idx = wr_addr[IW+1:2];

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(lk_valid) |-> (!b2_valid && !b3_valid)); // R2

  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (!b2_valid && !b3_valid)); // R3

  AST_B3_NEEDS_B2: assert property (@(posedge clk) disable iff (!rst_n)
    b3_valid |-> b2_valid); // R6

  AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en, 2) && $past(wr_valid, 2) && $past(lk_valid)
     && ($past(lk_addr) == $past(wr_addr, 2))
     && !($past(wr_en) && ($past(wr_idx) == $past(lk_idx))))
    |-> b2_valid); // R8

  AST_CLEAR_THEN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en, 2) && !$past(wr_valid, 2) && $past(lk_valid)
     && ($past(lk_idx) == $past(wr_idx, 2))
     && !($past(wr_en) && ($past(wr_idx) == $past(lk_idx))))
    |-> !b2_valid); // R10
endmodule

bind brtc_top brtc_chk #(.ENTRIES(ENTRIES)) i_brtc_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .lk_valid (lk_valid),
  .lk_addr  (lk_addr),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_valid (wr_valid),
  .hit      (lookup_hit),
  .b2_valid (b2_valid),
  .b3_valid (b3_valid)
);

// File: tb/test_brtc_top.sv
module test_brtc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic [1:0]  lk_pred = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_addr = '0;
  logic        wr_valid = 1'b0;
  logic [1:0]  wr_type = '0;
  logic [31:0] wr_taddr = '0, wr_naddr = '0;
  logic        wr_st_valid = 1'b0, wr_sn_valid = 1'b0;
  logic [1:0]  wr_st_type = '0, wr_sn_type = '0;
  logic [31:0] wr_tt = '0, wr_tn = '0, wr_nt = '0, wr_nn = '0;
  logic        b2_valid, b3_valid;
  logic [31:0] b2_addr, b3_addr;
  logic [1:0]  b2_type, b3_type;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  brtc_top i_brtc_top (.*);

  // index bits [6:2]: A0 and A0X share index 4, A1 uses index 8
  localparam logic [31:0] A0  = 32'h0000_1010;
  localparam logic [31:0] A0X = 32'h0000_1090;
  localparam logic [31:0] A1  = 32'h0000_2020;
  localparam logic [31:0] BASE0 = 32'h4000_0000;
  localparam logic [31:0] BASE1 = 32'h5000_0000;

  typedef struct packed {
    logic       sel;
    logic [1:0] pred;
    logic [7:0] b2off;
    logic       b3v;
    logic [7:0] b3off;
    logic [1:0] b3type;
  } vec_t;

  // offsets: T 10, N 20, TT 30, TN 40, NT 50, NN 60; entry 0 st=1 sn=0, entry 1 st=0 sn=1
  localparam vec_t VECS [8] = '{
    '{1'b0, 2'b00, 8'h20, 1'b0, 8'h00, 2'd0},
    '{1'b0, 2'b01, 8'h10, 1'b1, 8'h40, 2'd2},
    '{1'b0, 2'b11, 8'h10, 1'b1, 8'h30, 2'd2},
    '{1'b0, 2'b10, 8'h20, 1'b0, 8'h00, 2'd0},
    '{1'b1, 2'b00, 8'h20, 1'b1, 8'h60, 2'd3},
    '{1'b1, 2'b01, 8'h10, 1'b0, 8'h00, 2'd0},
    '{1'b1, 2'b11, 8'h10, 1'b0, 8'h00, 2'd0},
    '{1'b1, 2'b10, 8'h20, 1'b1, 8'h50, 2'd3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_fill(input logic [31:0] a, input logic v, input logic [31:0] base,
                          input logic stv, input logic snv);
    wr_addr = a; wr_valid = v; wr_type = 2'd1;
    wr_taddr = base + 32'h10; wr_naddr = base + 32'h20;
    wr_tt = base + 32'h30; wr_tn = base + 32'h40;
    wr_nt = base + 32'h50; wr_nn = base + 32'h60;
    wr_st_valid = stv; wr_st_type = 2'd2;
    wr_sn_valid = snv; wr_sn_type = 2'd3;
  endtask

  task automatic fill(input logic [31:0] a, input logic v, input logic [31:0] base,
                      input logic stv, input logic snv);
    @(negedge clk);
    set_fill(a, v, base, stv, snv);
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // present at a negedge, captured at the next posedge, sampled at the following negedge
  task automatic look(input logic [31:0] a, input logic [1:0] p);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a; lk_pred = p;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset
    look(A0, 2'b01);
    chk("R1 b2_valid after reset", 32'(b2_valid), 32'd0);
    chk("R1 b3_valid after reset", 32'(b3_valid), 32'd0);

    fill(A0, 1'b1, BASE0, 1'b1, 1'b0);
    fill(A1, 1'b1, BASE1, 1'b0, 1'b1);

    // R4 R5 R6 R7: tree walk over all prediction pairs
    for (int i = 0; i < 8; i++) begin
      logic [31:0] base;
      base = VECS[i].sel ? BASE1 : BASE0;
      look(VECS[i].sel ? A1 : A0, VECS[i].pred);
      chk("R4 b2_valid", 32'(b2_valid), 32'd1);
      chk("R4 b2_addr", b2_addr, base + 32'(VECS[i].b2off));
      chk("R7 b2_type", 32'(b2_type), 32'd1);
      chk("R6 b3_valid", 32'(b3_valid), 32'(VECS[i].b3v));
      chk("R5 b3_addr", b3_addr, VECS[i].b3v ? base + 32'(VECS[i].b3off) : 32'd0);
      chk("R7 b3_type", 32'(b3_type), 32'(VECS[i].b3type));
    end

    // R2: no request in the previous cycle -> outputs drop
    @(negedge clk);
    chk("R2 idle b2_valid", 32'(b2_valid), 32'd0);
    chk("R2 idle b3_valid", 32'(b3_valid), 32'd0);

    // R3: same index, different tag
    look(A0X, 2'b11);
    chk("R3 alias miss b2_valid", 32'(b2_valid), 32'd0);
    chk("R3 alias miss b2_addr", b2_addr, 32'd0);
    chk("R3 alias miss b3_valid", 32'(b3_valid), 32'd0);

    // R8: overwrite index 4 with the alias tag
    fill(A0X, 1'b1, 32'h6000_0000, 1'b1, 1'b1);
    look(A0, 2'b01);
    chk("R8 old tag misses", 32'(b2_valid), 32'd0);
    look(A0X, 2'b00);
    chk("R8 new tag hits", 32'(b2_valid), 32'd1);
    chk("R8 new b3_addr", b3_addr, 32'h6000_0060);
    look(A1, 2'b10);
    chk("R8 other entry intact", b3_addr, BASE1 + 32'h50);

    // R9: write and lookup at the same edge return old content
    @(negedge clk);
    set_fill(A0X, 1'b1, 32'h7000_0000, 1'b1, 1'b1);
    wr_en = 1'b1;
    lk_valid = 1'b1; lk_addr = A0X; lk_pred = 2'b01;
    @(negedge clk);
    wr_en = 1'b0; lk_valid = 1'b0;
    chk("R9 same-edge old b2_addr", b2_addr, 32'h6000_0010);
    look(A0X, 2'b01);
    chk("R9 next lookup new b2_addr", b2_addr, 32'h7000_0010);

    // R10: write with primary valid clear empties the entry
    fill(A1, 1'b0, BASE1, 1'b1, 1'b1);
    look(A1, 2'b00);
    chk("R10 cleared entry b2_valid", 32'(b2_valid), 32'd0);
    chk("R10 cleared entry b3_valid", 32'(b3_valid), 32'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule